// File: doc/BRIEF.md
# Two-Stage Clock Divider Setting Search Engine

This block works out which setting of a two-stage clock divider comes closest to a requested output rate without going above it. A start strobe samples a target rate, a parent rate, a pre-divider and an M offset. The engine first reduces the parent rate once to a base value, `(parent / pre_div) / 10`. It then visits all 128 pairs of a 4-bit M and a 3-bit N. For each pair it computes `(base >> N) / (M + m_offset)` and keeps the best pair.

Every division runs on one shared restoring divider, which produces one quotient bit per cycle. A full search therefore takes roughly 130 divisions. When the last pair has been scored, the engine raises a one-cycle done pulse and presents the chosen M, N and rate. These stay stable until the next search. A divisor of zero never stalls the divider: that quotient is taken as zero and an error flag is raised for the search.

Top module: `clkdiv_search`

## Requirements
- R1: After reset `done_o`, `m_o`, `n_o`, `rate_o` and `err_o` are all 0.
- R2: The rate of a pair is `((parent / pre_div) / 10) >> N`, divided by `(M + m_offset)`. Each division truncates, and M and N are taken as unsigned fields of 4 and 3 bits.
- R3: A pair whose rate is above the target is never chosen, so `rate_o <= target` always holds at done.
- R4: Of the remaining pairs, the one with the smallest `target - rate` is reported.
- R5: Pairs are visited with M as the outer loop and N as the inner loop, both counting up from 0. A later pair replaces the held best only when it is strictly closer, so the earliest pair wins a tie.
- R6: The held best starts each search at M=0, N=0 and rate 0. If no pair has a nonzero rate at or below the target, the result is M=0, N=0 and rate 0.
- R7: Target, parent, pre-divider and M offset are sampled when a start is accepted. Changing them during a search has no effect on its result.
- R8: `done_o` is high for exactly one cycle after the last pair is scored. `m_o`, `n_o`, `rate_o` and `err_o` then hold until the next start is accepted.
- R9: A pre-divider of 0 gives a base of 0 and sets `err_o`. An M of 0 with an M offset of 0 scores that pair as rate 0 and sets `err_o`. In both cases the search still completes.
- R10: A start strobe that arrives while a search is running is ignored: there is no restart and no second done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a search when the engine is idle |
| target_i | input | RATE_W | Requested output rate |
| parent_i | input | RATE_W | Parent clock rate |
| pre_div_i | input | PRE_W | Pre-divider value |
| m_off_i | input | MOFF_W | Offset added to M to form the second divisor |
| done_o | output | 1 | One-cycle pulse when the search finishes |
| m_o | output | M_W | Chosen M |
| n_o | output | N_W | Chosen N |
| rate_o | output | RATE_W | Rate the chosen pair gives |
| err_o | output | 1 | A zero divisor was met during the last search |

## Verification
The bench targets ties between pairs that give the same rate, such as M=0 with N=1 against M=1 with N=0 when the offset is 1. A design that replaced the best on equality, or walked N in the outer loop, would report the later pair. It also drives targets below every nonzero rate, where a design that let a zero-rate pair overwrite the initial best, or that skipped the reset of the best, would report a nonzero pair. It also applies zero divisors from both sources; a divider without the zero guard would hang or report garbage. Finally, it changes the inputs and strobes start in the middle of a search, which exposes a design that reads live inputs or restarts.

// File: rtl/clkdiv_search_pkg.sv
package clkdiv_search_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_PRE_GO, S_PRE_W, S_TEN_GO, S_TEN_W, S_CAND_GO, S_CAND_W, S_DONE
  } state_e;
endpackage

// File: rtl/div_seq.sv
module div_seq #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         done_o,
  output logic [W-1:0] quot_o,
  output logic         dz_o
);
  localparam int CW = $clog2(W + 1);

  logic          busy_q, done_q, dz_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  rem_q, quo_q, dvs_q;
  logic [W:0]    trial;
  logic          ge;

  assign trial = {rem_q, quo_q[W-1]};
  assign ge    = trial >= {1'b0, dvs_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      dz_q   <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        if (divisor_i == '0) begin
          done_q <= 1'b1;
          dz_q   <= 1'b1;
          quo_q  <= '0;
        end else begin
          busy_q <= 1'b1;
          dz_q   <= 1'b0;
          cnt_q  <= CW'(W);
          rem_q  <= '0;
          quo_q  <= dividend_i;
          dvs_q  <= divisor_i;
        end
      end else if (busy_q) begin
        rem_q <= ge ? W'(trial - {1'b0, dvs_q}) : trial[W-1:0];
        quo_q <= {quo_q[W-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = quo_q;
  assign dz_o   = dz_q;

  // R9
  dz_zero_quot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q && divisor_i == '0) |=> (done_o && dz_o && quot_o == '0));

  // R8
  div_done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  div_busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q > CW'(1)) |=> (busy_q && !done_o));
endmodule

// File: rtl/best_sel.sv
module best_sel #(
  parameter int RATE_W = 32,
  parameter int M_W    = 4,
  parameter int N_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              upd_i,
  input  logic [RATE_W-1:0] cand_i,
  input  logic [M_W-1:0]    cand_m_i,
  input  logic [N_W-1:0]    cand_n_i,
  input  logic [RATE_W-1:0] target_i,
  output logic [RATE_W-1:0] best_o,
  output logic [M_W-1:0]    best_m_o,
  output logic [N_W-1:0]    best_n_o
);
  logic [RATE_W-1:0] best_q;
  logic [M_W-1:0]    m_q;
  logic [N_W-1:0]    n_q;
  logic              fits, closer;

  assign fits   = cand_i <= target_i;
  // strict: equal distance keeps the earlier pair
  assign closer = (target_i - cand_i) < (target_i - best_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      best_q <= '0;
      m_q    <= '0;
      n_q    <= '0;
    end else if (clr_i) begin
      best_q <= '0;
      m_q    <= '0;
      n_q    <= '0;
    end else if (upd_i && fits && closer) begin
      best_q <= cand_i;
      m_q    <= cand_m_i;
      n_q    <= cand_n_i;
    end
  end

  assign best_o   = best_q;
  assign best_m_o = m_q;
  assign best_n_o = n_q;

  // R3
  best_le_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |-> best_q <= target_i);

  // R4
  best_monotone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> best_q >= $past(best_q));

  // R6
  best_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (best_q == '0 && m_q == '0 && n_q == '0));
endmodule

// File: rtl/clkdiv_search.sv
module clkdiv_search
  import clkdiv_search_pkg::*;
#(
  parameter int RATE_W = 32,
  parameter int PRE_W  = 8,
  parameter int MOFF_W = 4,
  parameter int M_W    = 4,
  parameter int N_W    = 3,
  parameter int POST   = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [RATE_W-1:0] target_i,
  input  logic [RATE_W-1:0] parent_i,
  input  logic [PRE_W-1:0]  pre_div_i,
  input  logic [MOFF_W-1:0] m_off_i,
  output logic              done_o,
  output logic [M_W-1:0]    m_o,
  output logic [N_W-1:0]    n_o,
  output logic [RATE_W-1:0] rate_o,
  output logic              err_o
);
  localparam logic [M_W-1:0] M_LAST = '1;
  localparam logic [N_W-1:0] N_LAST = '1;

  state_e            state_q;
  logic [RATE_W-1:0] target_q, parent_q, base_q;
  logic [PRE_W-1:0]  pre_q;
  logic [MOFF_W-1:0] moff_q;
  logic [M_W-1:0]    m_q;
  logic [N_W-1:0]    n_q;
  logic              err_q;

  logic              d_start, d_done, d_dz;
  logic [RATE_W-1:0] d_a, d_b, d_q;
  logic              last_pair;

  assign last_pair = (m_q == M_LAST) && (n_q == N_LAST);

  always_comb begin
    d_start = 1'b0;
    d_a     = '0;
    d_b     = '0;
    unique case (state_q)
      S_PRE_GO: begin
        d_start = 1'b1;
        d_a     = parent_q;
        d_b     = RATE_W'(pre_q);
      end
      S_TEN_GO: begin
        d_start = 1'b1;
        d_a     = base_q;
        d_b     = RATE_W'(POST);
      end
      S_CAND_GO: begin
        d_start = 1'b1;
        d_a     = base_q >> n_q;
        d_b     = RATE_W'(m_q) + RATE_W'(moff_q);
      end
      default: ;
    endcase
  end

  div_seq #(.W(RATE_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (d_start),
    .dividend_i (d_a),
    .divisor_i  (d_b),
    .done_o     (d_done),
    .quot_o     (d_q),
    .dz_o       (d_dz)
  );

  logic clr, upd;
  assign clr = (state_q == S_IDLE) && start_i;
  assign upd = (state_q == S_CAND_W) && d_done;

  best_sel #(.RATE_W(RATE_W), .M_W(M_W), .N_W(N_W)) u_best (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .upd_i    (upd),
    .cand_i   (d_q),
    .cand_m_i (m_q),
    .cand_n_i (n_q),
    .target_i (target_q),
    .best_o   (rate_o),
    .best_m_o (m_o),
    .best_n_o (n_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      target_q <= '0;
      parent_q <= '0;
      base_q   <= '0;
      pre_q    <= '0;
      moff_q   <= '0;
      m_q      <= '0;
      n_q      <= '0;
      err_q    <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          target_q <= target_i;
          parent_q <= parent_i;
          pre_q    <= pre_div_i;
          moff_q   <= m_off_i;
          m_q      <= '0;
          n_q      <= '0;
          err_q    <= 1'b0;
          state_q  <= S_PRE_GO;
        end
        S_PRE_GO: state_q <= S_PRE_W;
        S_PRE_W: if (d_done) begin
          base_q  <= d_q;
          if (d_dz) err_q <= 1'b1;
          state_q <= S_TEN_GO;
        end
        S_TEN_GO: state_q <= S_TEN_W;
        S_TEN_W: if (d_done) begin
          base_q  <= d_q;
          state_q <= S_CAND_GO;
        end
        S_CAND_GO: state_q <= S_CAND_W;
        S_CAND_W: if (d_done) begin
          if (d_dz) err_q <= 1'b1;
          if (last_pair) begin
            state_q <= S_DONE;
          end else begin
            if (n_q == N_LAST) m_q <= m_q + 1'b1;
            n_q     <= n_q + 1'b1;
            state_q <= S_CAND_GO;
          end
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign done_o = (state_q == S_DONE);
  assign err_o  = err_q;

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  hold_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && !start_i) |=> ($stable(rate_o) && $stable(m_o) && $stable(n_o) && $stable(err_o)));

  // R9
  pre_zero_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && pre_q == '0) |-> (err_o && rate_o == '0));

  // R3
  done_le_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> rate_o <= target_q);

  // R7
  cfg_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_IDLE) |=> ($stable(target_q) && $stable(pre_q) && $stable(moff_q)));
endmodule

// File: tb/clkdiv_search_tb.sv
module clkdiv_search_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] target_i = '0, parent_i = '0;
  logic [7:0]  pre_div_i = '0;
  logic [3:0]  m_off_i = '0;
  logic        done_o, err_o;
  logic [3:0]  m_o;
  logic [2:0]  n_o;
  logic [31:0] rate_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #10 clk_i = ~clk_i;

  clkdiv_search u_dut (
    .clk_i, .rst_ni, .start_i, .target_i, .parent_i, .pre_div_i, .m_off_i,
    .done_o, .m_o, .n_o, .rate_o, .err_o
  );

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 190000) begin
      failures++;
      $display("FAIL watchdog: run did not end, actual cycles=%0d expected<=190000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  // Arithmetic model: M outer, N inner, strict improvement only
  task automatic model(input logic [31:0] tgt, par, input logic [7:0] pre, input logic [3:0] moff,
                       output logic [3:0] em, output logic [2:0] en,
                       output logic [31:0] er, output logic ee);
    logic [31:0] base, r, d;
    ee = (pre == 0);
    base = (pre == 0) ? 32'd0 : (par / {24'd0, pre}) / 32'd10;
    em = 0; en = 0; er = 0;
    for (int m = 0; m < 16; m++) begin
      for (int n = 0; n < 8; n++) begin
        d = 32'(m) + {28'd0, moff};
        if (d == 0) begin
          ee = 1'b1;
          r = 0;
        end else begin
          r = (base >> n) / d;
        end
        if (r <= tgt && (tgt - r) < (tgt - er)) begin
          er = r; em = 4'(m); en = 3'(n);
        end
      end
    end
  endtask

  task automatic wait_done(output bit got);
    got = 1'b0;
    for (int i = 0; i < 8000; i++) begin
      @(negedge clk_i);
      if (done_o) begin
        got = 1'b1;
        break;
      end
    end
  endtask

  task automatic launch(input logic [31:0] tgt, par, input logic [7:0] pre, input logic [3:0] moff);
    @(negedge clk_i);
    target_i = tgt; parent_i = par; pre_div_i = pre; m_off_i = moff;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic finish_and_check(input logic [31:0] tgt, par, input logic [7:0] pre,
                                  input logic [3:0] moff, input string req);
    logic [3:0] em; logic [2:0] en; logic [31:0] er; logic ee; bit got;
    logic [31:0] hold_r;
    model(tgt, par, pre, moff, em, en, er, ee);
    wait_done(got);
    check(got, req, $sformatf("done seen actual=%0d expected=1", got));
    check(m_o == em && n_o == en && rate_o == er && err_o == ee, req,
          $sformatf("actual m=%0d n=%0d rate=%0d err=%0d expected m=%0d n=%0d rate=%0d err=%0d",
                    m_o, n_o, rate_o, err_o, em, en, er, ee));
    hold_r = rate_o;
    @(negedge clk_i);
    // R8: single-cycle pulse, result held
    check(!done_o && rate_o == hold_r && m_o == em && n_o == en, "R8",
          $sformatf("after done actual done=%0d rate=%0d expected done=0 rate=%0d", done_o, rate_o, hold_r));
  endtask

  task automatic search(input logic [31:0] tgt, par, input logic [7:0] pre,
                        input logic [3:0] moff, input string req);
    launch(tgt, par, pre, moff);
    finish_and_check(tgt, par, pre, moff, req);
  endtask

  initial begin
    logic [31:0] seed;
    repeat (3) @(negedge clk_i);
    // R1: reset values
    check(!done_o && m_o == 0 && n_o == 0 && rate_o == 0 && !err_o, "R1",
          $sformatf("reset actual done=%0d m=%0d n=%0d rate=%0d err=%0d expected all 0",
                    done_o, m_o, n_o, rate_o, err_o));
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    search(32'd100000, 32'd24000000, 8'd1, 4'd1, "R2");
    search(32'd400000, 32'd297000000, 8'd2, 4'd2, "R4");
    // R5: M=0,N=1 and M=1,N=0 both give 50000; earlier pair wins
    search(32'd50000, 32'd1000000, 8'd1, 4'd1, "R5");
    search(32'd25000, 32'd1000000, 8'd1, 4'd1, "R5");
    // R6: target below every nonzero rate
    search(32'd100, 32'd100000000, 8'd1, 4'd1, "R6");
    // R6: parent so small that every rate is zero
    search(32'd1000, 32'd5, 8'd1, 4'd1, "R6");
    // R3: target above every rate
    search(32'hFFFF_FFFF, 32'd50000000, 8'd1, 4'd1, "R3");
    search(32'd123457, 32'hFFFF_FFFF, 8'd3, 4'd15, "R3");
    // R9: zero pre-divider, and zero M offset
    search(32'd5000, 32'd10000000, 8'd0, 4'd3, "R9");
    search(32'd77777, 32'd10000000, 8'd1, 4'd0, "R9");

    // R7 and R10: change inputs and strobe start mid-search
    launch(32'd300000, 32'd60000000, 8'd4, 4'd2);
    repeat (40) @(negedge clk_i);
    target_i = 32'd1; parent_i = 32'd999; pre_div_i = 8'd9; m_off_i = 4'd7;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    finish_and_check(32'd300000, 32'd60000000, 8'd4, 4'd2, "R7");
    begin
      bit extra = 1'b0;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk_i);
        if (done_o) extra = 1'b1;
      end
      check(!extra, "R10", $sformatf("second done actual=%0d expected=0", extra));
    end

    seed = 32'h1234_5678;
    for (int k = 0; k < 6; k++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      search({8'd0, seed[23:0]} + 32'd1000, seed ^ 32'h5A5A_0000, {4'd0, seed[27:24]} + 8'd1,
             seed[31:28], "R4");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule